// File: doc/BRIEF.md
# Saturating Two-Digit Decimal Up/Down Counter

This block holds a value between 0 and 99 that two push buttons raise or lower by one. The buttons are active-low. Each one passes through a synchronizer, and the block samples them only on cycles where a single-cycle `tick` enable is high. A sample is compared with a latched copy of the previous sample. Only a change from released to pressed moves the value. Holding a button or letting it go has no effect. The value stops at the ends of its range and does not wrap.

Whenever the value changes, a small sequential converter splits it into a tens digit and a ones digit. The converter makes four restoring trial subtractions, one per clock cycle, with weights 80, 40, 20 and 10. Each trial that fits sets one bit of the tens digit, most significant first, and what is left at the end is the ones digit. While the converter runs, `digits_valid` is low and both digit outputs keep their old values. The new pair is written in a single cycle. The display driver and the tick source lie outside this block.

Top module: `bcd_updn_counter`

## Requirements
- R1: While `rst` is high, and after it falls until the first step, `count` is 0, `tens` and `ones` are 0, and `digits_valid` is 1. The latched button state is cleared to released.
- R2: Button inputs have an effect only on a `tick` cycle. A button level reaches the sampler two clock cycles after it is applied. A press and release that both fall between two ticks leaves the count unchanged.
- R3: A button that is pressed (input 0) on a tick after being released on the previous tick moves `count` by one: `btn_up_n` raises it and `btn_dn_n` lowers it. A button that stays pressed across ticks, or that is released, causes no step.
- R4: If both buttons show a fresh press on the same tick, `count` moves down.
- R5: `count` never leaves 0..99. An up step at 99 leaves 99, and a down step at 0 leaves 0. A blocked step does not start a conversion.
- R6: After the clock edge where `count` changes, `digits_valid` is low for exactly four cycles. It then rises with `tens` = count/10 and `ones` = count mod 10.
- R7: While `digits_valid` is low, `tens` and `ones` hold the values they had before the conversion started.
- R8: A step taken while a conversion is running updates `count` on that tick and restarts the conversion, so `digits_valid` stays low for four cycles after the new change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle sampling enable |
| btn_up_n | input | 1 | Up button, active low, asynchronous |
| btn_dn_n | input | 1 | Down button, active low, asynchronous |
| count | output | 7 | Binary count, 0..99 |
| tens | output | 4 | BCD tens digit |
| ones | output | 4 | BCD ones digit |
| digits_valid | output | 1 | High when tens/ones match count |

## Verification
Two functions can act in the same cycle. A fresh press that lands on a tick while the BCD converter is part-way through must both change the count and throw away the partial result. The bench provokes this by pressing up on one tick and then pressing down two cycles later, while up is still held. The test passes only if the count returns to its earlier value, the old digits stay frozen, and `digits_valid` stays low until four cycles after the second tick. A second overlap is two fresh presses on the same tick, where the down step must win. Both cases are judged against a behavioural reference model that is compared on every clock.

// File: rtl/updn_pkg.sv
package updn_pkg;

    localparam int CNT_W   = 7;
    localparam int DIG_W   = 4;
    localparam int CNT_MAX = 99;
    localparam int TRIALS  = 4;
    localparam int IDX_W   = $clog2(TRIALS);

    typedef struct packed {
        logic up;
        logic dn;
    } btn_t;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;

    typedef struct packed {
        logic [DIG_W-1:0] tens;
        logic [DIG_W-1:0] ones;
    } bcd_t;

    // weight for trial idx: 80, 40, 20, 10
    function automatic logic [CNT_W-1:0] trial_weight(input logic [IDX_W-1:0] idx);
        return CNT_W'(10 << (TRIALS - 1 - int'(idx)));
    endfunction

endpackage

// File: rtl/updn_btn_sync.sv
module updn_btn_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_n,
    output logic [WIDTH-1:0] pressed
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= '1;
            else     chain_q <= {chain_q[STAGES-2:0], raw_n[i]};
        end
        assign pressed[i] = ~chain_q[STAGES-1];
    end
endmodule

// File: rtl/updn_press_detect.sv
module updn_press_detect
    import updn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  btn_t pressed,
    output btn_t fresh
);
    btn_t held_q;

    always_ff @(posedge clk) begin
        if (rst)       held_q <= '0;
        else if (tick) held_q <= pressed;
    end

    always_comb begin
        fresh = '0;
        if (tick) fresh = btn_t'(pressed & ~held_q);
    end
endmodule

// File: rtl/updn_sat_count.sv
module updn_sat_count
    import updn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  btn_t             fresh,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nxt,
    output logic             changed
);
    step_e            step;
    logic [CNT_W-1:0] count_q;

    always_comb begin
        if (fresh.dn)      step = STEP_DN;
        else if (fresh.up) step = STEP_UP;
        else               step = STEP_NONE;
    end

    always_comb begin
        count_nxt = count_q;
        unique case (step)
            STEP_UP:   if (count_q != CNT_W'(CNT_MAX)) count_nxt = count_q + 1'b1;
            STEP_DN:   if (count_q != '0)              count_nxt = count_q - 1'b1;
            default:   count_nxt = count_q;
        endcase
    end

    assign changed = (count_nxt != count_q);

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_nxt;
    end

    assign count = count_q;
endmodule

// File: rtl/updn_bcd_conv.sv
module updn_bcd_conv
    import updn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] value,
    output bcd_t             digits,
    output logic             valid
);
    logic [CNT_W-1:0] rem_q, rem_n, weight;
    logic [DIG_W-1:0] acc_q, acc_n;
    logic [IDX_W-1:0] idx_q;
    logic             busy_q;
    logic [CNT_W:0]   diff;
    logic             fits;
    bcd_t             digits_q;

    assign weight = trial_weight(idx_q);
    assign diff   = {1'b0, rem_q} - {1'b0, weight};
    assign fits   = ~diff[CNT_W];
    assign rem_n  = fits ? diff[CNT_W-1:0] : rem_q;
    assign acc_n  = {acc_q[DIG_W-2:0], fits};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q    <= '0;
            acc_q    <= '0;
            idx_q    <= '0;
            busy_q   <= 1'b0;
            digits_q <= '0;
        end else if (start) begin
            rem_q  <= value;
            acc_q  <= '0;
            idx_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            rem_q <= rem_n;
            acc_q <= acc_n;
            if (idx_q == IDX_W'(TRIALS - 1)) begin
                busy_q        <= 1'b0;
                digits_q.tens <= acc_n;
                digits_q.ones <= DIG_W'(rem_n);
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign digits = digits_q;
    assign valid  = ~busy_q;
endmodule

// File: rtl/bcd_updn_counter.sv
module bcd_updn_counter
    import updn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             btn_up_n,
    input  logic             btn_dn_n,
    output logic [CNT_W-1:0] count,
    output logic [DIG_W-1:0] tens,
    output logic [DIG_W-1:0] ones,
    output logic             digits_valid
);
    btn_t             pressed, fresh;
    logic [1:0]       pressed_vec;
    logic [CNT_W-1:0] count_nxt;
    logic             changed;
    bcd_t             digits;

    updn_btn_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst(rst),
        .raw_n({btn_up_n, btn_dn_n}),
        .pressed(pressed_vec)
    );
    assign pressed = btn_t'(pressed_vec);

    updn_press_detect u_detect (
        .clk(clk), .rst(rst), .tick(tick),
        .pressed(pressed), .fresh(fresh)
    );

    updn_sat_count u_count (
        .clk(clk), .rst(rst), .fresh(fresh),
        .count(count), .count_nxt(count_nxt), .changed(changed)
    );

    updn_bcd_conv u_conv (
        .clk(clk), .rst(rst), .start(changed), .value(count_nxt),
        .digits(digits), .valid(digits_valid)
    );

    assign tens = digits.tens;
    assign ones = digits.ones;
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [6:0] count,
    input logic [3:0] tens,
    input logic [3:0] ones,
    input logic       digits_valid
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R5
    count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        count <= 7'd99);

    // R3
    unit_step_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (count != $past(count)) |->
            (count == $past(count) + 7'd1 || count == $past(count) - 7'd1));

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$past(tick) |-> $stable(count));

    // R6
    digits_match_chk: assert property (@(posedge clk) disable iff (rst)
        digits_valid |-> (int'(tens) * 10 + int'(ones) == int'(count)));

    // R7
    digits_frozen_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !digits_valid |-> ($stable(tens) && $stable(ones)));

    // R6
    busy_min_len_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $fell(digits_valid) |=> !digits_valid);
endmodule

bind bcd_updn_counter updn_counter_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .count(count),
    .tens(tens), .ones(ones), .digits_valid(digits_valid)
);

// File: tb/bcd_updn_counter_tb.sv
module bcd_updn_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       btn_up_n = 1'b1;
    logic       btn_dn_n = 1'b1;
    logic [6:0] count;
    logic [3:0] tens, ones;
    logic       digits_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bcd_updn_counter u_dut (
        .clk(clk), .rst(rst), .tick(tick),
        .btn_up_n(btn_up_n), .btn_dn_n(btn_dn_n),
        .count(count), .tens(tens), .ones(ones), .digits_valid(digits_valid)
    );

    // behavioural reference model
    int m_cnt, m_tens, m_ones, m_wait, m_pend;
    bit m_up_last, m_dn_last;
    logic q_up[$], q_dn[$];

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_tens = 0; m_ones = 0; m_wait = 0; m_pend = 0;
            m_up_last = 0; m_dn_last = 0;
            q_up = '{1'b1, 1'b1}; q_dn = '{1'b1, 1'b1};
        end else begin
            bit pu, pd, fu, fd, restarted;
            int nc;
            pu = !q_up[0]; pd = !q_dn[0];
            restarted = 0;
            if (tick) begin
                fu = pu && !m_up_last; fd = pd && !m_dn_last;
                m_up_last = pu; m_dn_last = pd;
                nc = m_cnt;
                if (fd)      nc = (m_cnt > 0)  ? m_cnt - 1 : m_cnt;
                else if (fu) nc = (m_cnt < 99) ? m_cnt + 1 : m_cnt;
                if (nc != m_cnt) begin
                    m_cnt = nc; m_pend = nc; m_wait = 4; restarted = 1;
                end
            end
            if (!restarted && m_wait > 0) begin
                m_wait--;
                if (m_wait == 0) begin
                    m_tens = m_pend / 10; m_ones = m_pend % 10;
                end
            end
            void'(q_up.pop_front()); void'(q_dn.pop_front());
            q_up.push_back(btn_up_n); q_dn.push_back(btn_dn_n);
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3/R5 count", int'(count), m_cnt);
            check("R6/R7 tens", int'(tens), m_tens);
            check("R6/R7 ones", int'(ones), m_ones);
            check("R6/R8 valid", int'(digits_valid), (m_wait == 0) ? 1 : 0);
        end
    end

    task automatic cyc(input logic u, input logic d, input logic t);
        @(negedge clk);
        btn_up_n = ~u; btn_dn_n = ~d; tick = t;
    endtask

    task automatic hold(input logic u, input logic d, input int n, input logic t_last);
        for (int i = 0; i < n; i++) cyc(u, d, t_last && (i == n - 1));
    endtask

    task automatic push(input logic u, input logic d);
        hold(u, d, 3, 1'b1);
        hold(1'b0, 1'b0, 3, 1'b1);
        hold(1'b0, 1'b0, 6, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got 0 expected 1 (run finished)");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 count", int'(count), 0);
        check("R1 valid", int'(digits_valid), 1);
        check("R1 tens", int'(tens), 0);
        rst = 1'b0;
        hold(1'b0, 1'b0, 4, 1'b1);
        check("R1 idle count", int'(count), 0);

        // R3 single up steps
        push(1'b1, 1'b0); push(1'b1, 1'b0); push(1'b1, 1'b0);
        check("R3 up x3", int'(count), 3);
        check("R6 digits 3", int'(ones), 3);

        // R3 held button, several ticks: only one step
        hold(1'b1, 1'b0, 3, 1'b1);
        for (int i = 0; i < 4; i++) hold(1'b1, 1'b0, 3, 1'b1);
        hold(1'b0, 1'b0, 3, 1'b1);
        hold(1'b0, 1'b0, 6, 1'b0);
        check("R3 held", int'(count), 4);

        // R2 press and release between ticks
        hold(1'b1, 1'b0, 4, 1'b0);
        hold(1'b0, 1'b0, 4, 1'b1);
        hold(1'b0, 1'b0, 6, 1'b0);
        check("R2 between ticks", int'(count), 4);

        // R4 both fresh together
        push(1'b1, 1'b1);
        check("R4 down wins", int'(count), 3);

        // R6 conversion timing
        hold(1'b1, 1'b0, 3, 1'b1);
        cyc(1'b1, 1'b0, 1'b0);
        check("R6 valid low", int'(digits_valid), 0);
        check("R7 old ones", int'(ones), 3);
        hold(1'b1, 1'b0, 3, 1'b0);
        check("R6 still low", int'(digits_valid), 0);
        cyc(1'b1, 1'b0, 1'b0);
        check("R6 valid back", int'(digits_valid), 1);
        check("R6 new ones", int'(ones), 4);
        hold(1'b0, 1'b0, 3, 1'b1);

        // R8 step during conversion
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b1);
        hold(1'b1, 1'b1, 4, 1'b0);
        check("R8 restart valid", int'(digits_valid), 0);
        check("R8 count back", int'(count), 4);
        cyc(1'b1, 1'b1, 1'b0);
        check("R8 valid after", int'(digits_valid), 1);
        hold(1'b0, 1'b0, 3, 1'b1);
        hold(1'b0, 1'b0, 6, 1'b0);

        // R5 upper clamp
        for (int i = 0; i < 100; i++) push(1'b1, 1'b0);
        check("R5 top", int'(count), 99);
        check("R5 tens 9", int'(tens), 9);
        hold(1'b1, 1'b0, 3, 1'b1);
        cyc(1'b1, 1'b0, 1'b0);
        check("R5 no conv at top", int'(digits_valid), 1);
        hold(1'b0, 1'b0, 3, 1'b1);

        // walk down through every value, R6 checked by model
        for (int i = 0; i < 101; i++) push(1'b0, 1'b1);
        check("R5 bottom", int'(count), 0);
        push(1'b0, 1'b1);
        check("R5 stay 0", int'(count), 0);

        hold(1'b0, 1'b0, 4, 1'b0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule